// File: doc/BRIEF.md
# Calendar Time Registers with Commit-Busy Flags

This block keeps wall-clock time and calendar date in two packed binary registers and advances them on a one-second tick input. Each tick adds one second. The seconds carry into minutes, the minutes into hours, and the hours into the day. The day rolls over at the end of each month, using a month-length rule and a stored leap-year flag. December rolls into January of the next year, and the leap flag is recomputed for the new year.

Software reaches the block through a simple register port with three addresses:

- address 0: control
- address 1: time
- address 2: date

A write to the time or date register is not applied at once. The value is held pending for `COMMIT_TICKS` pulses of a slow-clock enable, and only then copied into the counting registers. While a write is pending, its busy flag in the control register reads 1. Software polls that flag before it issues the next write. Because the two registers can change between reads, a consistent snapshot needs two matching back-to-back reads of both registers.

Top module: `cal_clock_regs`

## Requirements
- R1: After reset the time register reads 0, the date register reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and the control register reads 0.
- R2: Time layout: seconds in [5:0], minutes in [13:8], hours in [20:16]. On `sec_tick` the seconds roll from 59 to 0 and carry into minutes. The minutes roll from 59 to 0 and carry into hours. The hours roll from 23 to 0.
- R3: Date layout: day in [4:0], month 1..12 in [11:8], year offset from 1970 in [21:16], leap flag in bit 22. When the hours wrap, the day advances. After day 30 of months 4, 6, 9 and 11, and after day 31 of the other months except February, the day returns to 1 and the month advances.
- R4: February ends after day 29 when the stored leap flag is 1 and after day 28 when it is 0.
- R5: When December ends, the month becomes 1 and the year offset increments, wrapping from 63 to 0. The leap flag becomes 1 exactly when (year offset + 1970) is divisible by 4.
- R6: A write to the time register sets control bit 8. The bit stays set until the value is committed, which happens on the `COMMIT_TICKS`-th `slow_en` pulse after the write. The bit clears in that same cycle.
- R7: A write to the date register sets control bit 7, with the same commit timing as R6.
- R8: Until a write is committed, the register reads its previous value, and that value keeps counting on ticks.
- R9: A write to a register whose busy bit is set is ignored. The first pending value is the one committed.
- R10: Control bit 9 (the alarm-write busy flag) and every other control bit outside [8:7] read 0. Writes to the control register change nothing.
- R11: If a commit and a `sec_tick` fall in the same cycle, the committed value is taken unchanged and is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | Slow-clock enable pulse that paces write commits |
| sec_tick | input | 1 | One-second tick, one `clk` cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 time, 2 date |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The time carry chain is checked with a grid of hour, minute and second values at 0, at one below the limit and at the limit. This grid separates each individual carry from the full carry into a new day. The calendar is checked by sweeping every month for a range of year offsets: the early years cover all four leap phases, and offsets 62 and 63 cover the year wrap. Each case starts at the last day at 23:59:59, so the sweep tells 30-day, 31-day and leap and non-leap February endings apart.

Commit timing is checked at each `slow_en` pulse. Further cases check a second write made while busy, a commit coinciding with a tick, and a write to the control register; these separate a correct pending path from one that commits early, overwrites the pending value or increments on commit.

// File: rtl/cal_clock_regs.sv
module cal_clock_regs #(
  parameter int COMMIT_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        sec_tick,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int CW = $clog2(COMMIT_TICKS + 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_TIME = 2'd1, A_DATE = 2'd2;

  logic [5:0] sec, min, yr;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic       leap;
  logic [20:0] pend_t;
  logic [22:0] pend_d;
  logic [CW-1:0] cnt_t, cnt_d;

  logic busy_t, busy_d, wr_t, wr_d, commit_t, commit_d;
  assign busy_t   = cnt_t != '0;
  assign busy_d   = cnt_d != '0;
  assign wr_t     = wr_en && addr == A_TIME && !busy_t;
  assign wr_d     = wr_en && addr == A_DATE && !busy_d;
  assign commit_t = slow_en && cnt_t == CW'(1);
  assign commit_d = slow_en && cnt_d == CW'(1);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata[31:23], wdata[15:14], wdata[7:6], ^pend_d[15:12], ^pend_d[7:5], ^pend_t[15:14], ^pend_t[7:6]};

  logic sec_w, min_w, hr_w, day_end;
  assign sec_w   = sec == 6'd59;
  assign min_w   = min == 6'd59;
  assign hr_w    = hr == 5'd23;
  assign day_end = sec_tick && sec_w && min_w && hr_w;

  logic [4:0] last_day;
  always_comb begin
    case (mon)
      4'd2:                      last_day = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
      default:                   last_day = 5'd31;
    endcase
  end

  logic [5:0] yr_inc;
  assign yr_inc = yr + 6'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_t <= '0;
      cnt_d <= '0;
      pend_t <= '0;
      pend_d <= '0;
    end else begin
      if (wr_t) begin
        cnt_t  <= CW'(COMMIT_TICKS);
        pend_t <= wdata[20:0];
      end else if (slow_en && busy_t) cnt_t <= cnt_t - CW'(1);
      if (wr_d) begin
        cnt_d  <= CW'(COMMIT_TICKS);
        pend_d <= wdata[22:0];
      end else if (slow_en && busy_d) cnt_d <= cnt_d - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0;
    end else if (commit_t) begin
      sec <= pend_t[5:0];
      min <= pend_t[13:8];
      hr  <= pend_t[20:16];
    end else if (sec_tick) begin
      sec <= sec_w ? 6'd0 : sec + 6'd1;
      if (sec_w) begin
        min <= min_w ? 6'd0 : min + 6'd1;
        if (min_w) hr <= hr_w ? 5'd0 : hr + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day <= 5'd1; mon <= 4'd1; yr <= '0; leap <= 1'b0;
    end else if (commit_d) begin
      day  <= pend_d[4:0];
      mon  <= pend_d[11:8];
      yr   <= pend_d[21:16];
      leap <= pend_d[22];
    end else if (day_end) begin
      if (day >= last_day) begin
        day <= 5'd1;
        if (mon >= 4'd12) begin
          mon  <= 4'd1;
          yr   <= yr_inc;
          leap <= yr_inc[1:0] == 2'd2;
        end else mon <= mon + 4'd1;
      end else day <= day + 5'd1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {22'd0, 1'b0, busy_t, busy_d, 7'd0};
      A_TIME:  rdata = {11'd0, hr, 2'd0, min, 2'd0, sec};
      A_DATE:  rdata = {9'd0, leap, yr, 4'd0, mon, 3'd0, day};
      default: rdata = '0;
    endcase
  end

  assert_time_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TIME && !busy_t) |=> busy_t);
  assert_time_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_t) |-> $past(slow_en));
  assert_date_busy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATE && !busy_d) |=> busy_d);
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !commit_t && sec_w) |=> sec == 6'd0);
  assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (day_end && !commit_d && day == last_day) |=> day == 5'd1);
endmodule

// File: tb/cal_clock_regs_bench.sv
module cal_clock_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0, slow_en = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cal_clock_regs #(.COMMIT_TICKS(2)) u_cal_clock_regs (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic t);
    slow_en = s; sec_tick = t;
    @(posedge clk); #1; slow_en = 1'b0; sec_tick = 1'b0;
  endtask

  function automatic logic [31:0] tpack(int h, int m, int s);
    return (h << 16) | (m << 8) | s;
  endfunction
  function automatic logic [31:0] dpack(int lp, int y, int mo, int d);
    return (lp << 22) | (y << 16) | (mo << 8) | d;
  endfunction
  function automatic int dim(int m, int lp);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic int lp_of(int y);
    return ((y + 1970) % 4 == 0) ? 1 : 0;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 time", v, 32'h0);
    rd(2'd2, v); chk("R1 date", v, 32'h00000101);

    // R6 / R8 / R9: pending time write
    wr(2'd1, tpack(10, 11, 12));
    rd(2'd0, v); chk("R6 busy set", v, 32'h100);
    wr(2'd1, tpack(1, 1, 1));
    pulse(1'b1, 1'b1);
    rd(2'd0, v); chk("R6 busy after one slow", v, 32'h100);
    rd(2'd1, v); chk("R8 old value counts", v, tpack(0, 0, 1));
    pulse(1'b1, 1'b0);
    rd(2'd0, v); chk("R6 busy clear", v, 32'h0);
    rd(2'd1, v); chk("R9 first value committed", v, tpack(10, 11, 12));

    // R7: pending date write
    wr(2'd2, dpack(1, 2, 3, 4));
    rd(2'd0, v); chk("R7 busy set", v, 32'h80);
    rd(2'd2, v); chk("R8 old date", v, 32'h00000101);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    rd(2'd0, v); chk("R7 busy clear", v, 32'h0);
    rd(2'd2, v); chk("R7 date committed", v, dpack(1, 2, 3, 4));

    // R10: control writes ignored
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); chk("R10 ctrl reads zero", v, 32'h0);
    rd(2'd1, v); chk("R10 time untouched", v, tpack(10, 11, 12));
    rd(2'd2, v); chk("R10 date untouched", v, dpack(1, 2, 3, 4));

    // R11: commit coincides with tick
    wr(2'd1, tpack(1, 2, 3));
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    rd(2'd1, v); chk("R11 commit wins over tick", v, tpack(1, 2, 3));
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R2 tick after commit", v, tpack(1, 2, 4));

    // R2: carry grid
    for (int hi = 0; hi < 3; hi++)
      for (int mi = 0; mi < 3; mi++)
        for (int si = 0; si < 3; si++) begin
          int h, m, s, tot;
          h = (hi == 0) ? 0 : 21 + hi;
          m = (mi == 0) ? 0 : 57 + mi;
          s = (si == 0) ? 0 : 57 + si;
          wr(2'd1, tpack(h, m, s));
          pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
          pulse(1'b0, 1'b1);
          tot = (h * 3600 + m * 60 + s + 1) % 86400;
          rd(2'd1, v);
          chk("R2 carry", v, tpack(tot / 3600, (tot / 60) % 60, tot % 60));
        end

    // R3 / R4 / R5: month-end sweep
    for (int yi = 0; yi < 10; yi++)
      for (int mo = 1; mo <= 12; mo++) begin
        int y, lp, d, ny, nm, nl;
        y = (yi < 8) ? yi : 54 + yi;
        lp = lp_of(y);
        d = dim(mo, lp);
        wr(2'd1, tpack(23, 59, 59));
        wr(2'd2, dpack(lp, y, mo, d));
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        ny = (mo == 12) ? (y + 1) % 64 : y;
        nm = (mo == 12) ? 1 : mo + 1;
        nl = (mo == 12) ? lp_of(ny) : lp;
        rd(2'd2, v);
        if (mo == 2) chk("R4 february end", v, dpack(nl, ny, nm, 1));
        else if (mo == 12) chk("R5 year end", v, dpack(nl, ny, nm, 1));
        else chk("R3 month end", v, dpack(nl, ny, nm, 1));
        rd(2'd1, v); chk("R2 midnight", v, 32'h0);
      end

    // R4: leap February day 28 advances to 29
    wr(2'd1, tpack(23, 59, 59));
    wr(2'd2, dpack(1, 2, 2, 28));
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    rd(2'd2, v); chk("R4 leap day 29", v, dpack(1, 2, 2, 29));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule